// File: doc/BRIEF.md
# Truth-Table Logic and Two's-Complement Arithmetic Unit

This is a purely combinational integer execution unit for a general-purpose datapath. It takes two operands, a carry/borrow input, a 4-bit operation select and a 4-bit logic function code. It returns a result of the operand width together with carry, zero, negative and overflow flags.

Logic operations do not have a separate gate each. The function code is a truth table. In every bit position, a 4-to-1 selector uses the two operand bits as its select lines and the four code bits as its data inputs. Any of the sixteen two-input Boolean functions is therefore one code value.

Arithmetic runs on a single ripple chain of full adders. An operand router in front of the chain covers add, add with carry, subtract, subtract with borrow, reverse subtract, negate, increment and decrement. It does so by swapping the operands, inverting one operand, forcing one operand to zero or all-ones, and choosing the injected carry.

Top module: `alu_tt_core`

## Requirements
- R1: With op_i = 0, result bit i equals func_i[2*a_i[i] + b_i[i]]. Code bit 3 is the output for a=1,b=1 and bit 0 is the output for a=0,b=0. So AND=1000, OR=1110, XOR=0110, XNOR=1001, NAND=0111, NOR=0001, 1100 passes A, 1010 passes B, 0011 gives NOT A, 0101 gives NOT B, 0000 gives zero and 1111 gives all-ones.
- R2: op_i = 1 gives A+B and op_i = 2 gives A+B+carry_i, both modulo 2^WIDTH.
- R3: op_i = 3 gives A-B and op_i = 4 gives A-B-carry_i, where carry_i acts as the borrow-in, modulo 2^WIDTH.
- R4: op_i = 5 gives B-A and op_i = 6 gives B-A-carry_i, modulo 2^WIDTH.
- R5: op_i = 7 gives -A and op_i = 8 gives -B, modulo 2^WIDTH.
- R6: op_i = 9 gives A+1, 10 gives B+1, 11 gives A-1 and 12 gives B-1, modulo 2^WIDTH.
- R7: carry_o behaves as follows for each class of operation:
  - For codes 1, 2 and 9 to 12 it is the unsigned carry out of the adder: it is set when the true unsigned sum exceeds 2^WIDTH-1. For a decrement this means the operand is nonzero.
  - For codes 3 to 8 it is a borrow: it is set when the unsigned minuend is smaller than the subtrahend plus the borrow-in. For a negation the minuend is 0.
  - For the logic code and the unused codes it is 0.
- R8: ovf_o is set for codes 1 to 12 exactly when the signed two's-complement result of the operation falls outside the signed range of WIDTH bits. It is 0 for the logic code and the unused codes.
- R9: zero_o is 1 exactly when every bit of result_o is 0, and neg_o equals the most significant bit of result_o.
- R10: op_i codes 13, 14 and 15 give result_o = 0, carry_o = 0 and ovf_o = 0, which makes zero_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| carry_i | input | 1 | Carry-in for code 2, borrow-in for codes 4 and 6 |
| op_i | input | 4 | Operation select (0 logic, 1-12 arithmetic, 13-15 unused) |
| func_i | input | 4 | Truth-table code for the logic operation |
| result_o | output | WIDTH | Result |
| carry_o | output | 1 | Carry or borrow flag |
| zero_o | output | 1 | Result is all zero |
| neg_o | output | 1 | Result sign bit |
| ovf_o | output | 1 | Signed overflow |

## Verification
The case hardest to reach is signed overflow on the paths with carry injection. Examples are A-B-borrow or B-A-borrow where the borrow itself pushes the result past the most negative value, negation of the most negative value, and decrement of it. Each of these needs one exact combination of operands and carry-in. The bench therefore runs every operand pair and both carry-in values through every arithmetic code at a 4-bit width. It computes the expected result, carry and overflow from signed and unsigned integer arithmetic, so those extreme pairs are all covered.

// File: rtl/alu_tt_pkg.sv
package alu_tt_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_LOGIC = 4'd0;
  localparam logic [OPW-1:0] OP_ADD   = 4'd1;
  localparam logic [OPW-1:0] OP_ADC   = 4'd2;
  localparam logic [OPW-1:0] OP_SUB   = 4'd3;
  localparam logic [OPW-1:0] OP_SBB   = 4'd4;
  localparam logic [OPW-1:0] OP_RSUB  = 4'd5;
  localparam logic [OPW-1:0] OP_RSBB  = 4'd6;
  localparam logic [OPW-1:0] OP_NEGA  = 4'd7;
  localparam logic [OPW-1:0] OP_NEGB  = 4'd8;
  localparam logic [OPW-1:0] OP_INCA  = 4'd9;
  localparam logic [OPW-1:0] OP_INCB  = 4'd10;
  localparam logic [OPW-1:0] OP_DECA  = 4'd11;
  localparam logic [OPW-1:0] OP_DECB  = 4'd12;

  // Truth-table selection: code bit index is {a,b}
  function automatic logic tt_pick(input logic [3:0] code, input logic a, input logic b);
    return code[{a, b}];
  endfunction

  // One full adder stage, returns {carry, sum}
  function automatic logic [1:0] fa_bit(input logic a, input logic b, input logic c);
    logic s;
    logic k;
    s = a ^ b ^ c;
    k = (a & b) | (a & c) | (b & c);
    return {k, s};
  endfunction

  function automatic logic is_arith(input logic [OPW-1:0] op);
    return (op >= OP_ADD) && (op <= OP_DECB);
  endfunction

  // Operations whose flag reports a borrow rather than a carry
  function automatic logic is_borrow(input logic [OPW-1:0] op);
    return (op >= OP_SUB) && (op <= OP_NEGB);
  endfunction

  // Signed overflow from the sign bits of the adder inputs and the sum
  function automatic logic sign_ovf(input logic xs, input logic ys, input logic ss);
    return (xs == ys) && (ss != xs);
  endfunction
endpackage

// File: rtl/alu_tt_logic.sv
module alu_tt_logic #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       code_i,
  output logic [WIDTH-1:0] y_o
);
  import alu_tt_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y_o[i] = tt_pick(code_i, a_i[i], b_i[i]);
  end

  always_comb begin
    // R1
    tt_zero_code_chk: assert (code_i != 4'b0000 || y_o == '0);
    // R1
    tt_and_code_chk: assert (code_i != 4'b1000 || y_o == (a_i & b_i));
  end
endmodule

// File: rtl/alu_tt_route.sv
module alu_tt_route #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]             a_i,
  input  logic [WIDTH-1:0]             b_i,
  input  logic                         carry_i,
  input  logic [alu_tt_pkg::OPW-1:0]   op_i,
  output logic [WIDTH-1:0]             x_o,
  output logic [WIDTH-1:0]             y_o,
  output logic                         cin_o
);
  import alu_tt_pkg::*;

  localparam logic [WIDTH-1:0] ZEROS = '0;
  localparam logic [WIDTH-1:0] ONES  = '1;

  always_comb begin
    x_o   = ZEROS;
    y_o   = ZEROS;
    cin_o = 1'b0;
    unique case (op_i)
      OP_ADD:  begin x_o = a_i;   y_o = b_i;  cin_o = 1'b0;     end
      OP_ADC:  begin x_o = a_i;   y_o = b_i;  cin_o = carry_i;  end
      OP_SUB:  begin x_o = a_i;   y_o = ~b_i; cin_o = 1'b1;     end
      OP_SBB:  begin x_o = a_i;   y_o = ~b_i; cin_o = ~carry_i; end
      OP_RSUB: begin x_o = b_i;   y_o = ~a_i; cin_o = 1'b1;     end
      OP_RSBB: begin x_o = b_i;   y_o = ~a_i; cin_o = ~carry_i; end
      OP_NEGA: begin x_o = ZEROS; y_o = ~a_i; cin_o = 1'b1;     end
      OP_NEGB: begin x_o = ZEROS; y_o = ~b_i; cin_o = 1'b1;     end
      OP_INCA: begin x_o = a_i;   y_o = ZEROS; cin_o = 1'b1;    end
      OP_INCB: begin x_o = b_i;   y_o = ZEROS; cin_o = 1'b1;    end
      OP_DECA: begin x_o = a_i;   y_o = ONES; cin_o = 1'b0;     end
      OP_DECB: begin x_o = b_i;   y_o = ONES; cin_o = 1'b0;     end
      default: begin x_o = ZEROS; y_o = ZEROS; cin_o = 1'b0;    end
    endcase
  end
endmodule

// File: rtl/alu_tt_ripple.sv
module alu_tt_ripple #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  import alu_tt_pkg::*;

  logic [WIDTH:0] chain;
  assign chain[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic [1:0] ks;
    assign ks         = fa_bit(x_i[i], y_i[i], chain[i]);
    assign sum_o[i]   = ks[0];
    assign chain[i+1] = ks[1];
  end

  assign cout_o = chain[WIDTH];
endmodule

// File: rtl/alu_tt_core.sv
module alu_tt_core #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic [3:0]       op_i,
  input  logic [3:0]       func_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             ovf_o
);
  import alu_tt_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y;
  logic             add_cin;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             arith_sel;
  logic             borrow_sel;
  logic             logic_sel;

  alu_tt_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i(a_i), .b_i(b_i), .code_i(func_i), .y_o(logic_y)
  );

  alu_tt_route #(.WIDTH(WIDTH)) u_route (
    .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .op_i(op_i),
    .x_o(add_x), .y_o(add_y), .cin_o(add_cin)
  );

  alu_tt_ripple #(.WIDTH(WIDTH)) u_adder (
    .x_i(add_x), .y_i(add_y), .cin_i(add_cin),
    .sum_o(add_sum), .cout_o(add_cout)
  );

  assign arith_sel  = is_arith(op_i);
  assign borrow_sel = is_borrow(op_i);
  assign logic_sel  = (op_i == OP_LOGIC);

  always_comb begin
    if (arith_sel)      result_o = add_sum;
    else if (logic_sel) result_o = logic_y;
    else                result_o = '0;
  end

  assign carry_o = arith_sel & (add_cout ^ borrow_sel);
  assign ovf_o   = arith_sel & sign_ovf(add_x[MSB], add_y[MSB], add_sum[MSB]);
  assign zero_o  = ~|result_o;
  assign neg_o   = result_o[MSB];

  logic [WIDTH:0] add_ref;
  assign add_ref = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    // R2
    add_path_chk: assert (op_i != OP_ADD || {carry_o, result_o} == add_ref);
    // R5
    neg_path_chk: assert (op_i != OP_NEGA || (result_o + a_i) == {WIDTH{1'b0}});
    // R7
    logic_carry_chk: assert (!logic_sel || !carry_o);
    // R8
    no_overflow_chk: assert (arith_sel || !ovf_o);
    // R10
    unused_code_chk: assert (!(op_i > OP_DECB) || (result_o == '0 && zero_o && !carry_o));
  end
endmodule

// File: tb/alu_tt_core_tb.sv
module alu_tt_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BW   = 4;
  localparam int MASK = (1 << BW) - 1;
  localparam int SMAX = (1 << (BW - 1)) - 1;
  localparam int SMIN = -(1 << (BW - 1));

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [BW-1:0] a, b, res;
  logic          cin, cy, zf, nf, of;
  logic [3:0]    op, fn;

  alu_tt_core #(.WIDTH(BW)) u_dut (
    .a_i(a), .b_i(b), .carry_i(cin), .op_i(op), .func_i(fn),
    .result_o(res), .carry_o(cy), .zero_o(zf), .neg_o(nf), .ovf_o(of)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic check(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s op=%0d fn=%0d a=%0d b=%0d cin=%0d: got %0d expected %0d",
               tag, op, fn, a, b, cin, got, exp);
    end
  endtask

  function automatic int sx(input int u);
    return (u > SMAX) ? u - (1 << BW) : u;
  endfunction

  task automatic apply_and_check(input int o, input int f, input int ua, input int ub, input int c);
    int ur, sr, ecy, eres, eov;
    string tag;
    @(posedge clk);
    op = 4'(o); fn = 4'(f); a = BW'(ua); b = BW'(ub); cin = 1'(c);
    ur = 0; sr = 0; ecy = 0; eov = 0; tag = "R10";
    case (o)
      0:  begin tag = "R1"; ur = 0;
            for (int i = 0; i < BW; i++)
              ur |= ((f >> (2 * ((ua >> i) & 1) + ((ub >> i) & 1))) & 1) << i;
          end
      1:  begin tag = "R2"; ur = ua + ub;     ecy = int'(ur > MASK); sr = sx(ua) + sx(ub); end
      2:  begin tag = "R2"; ur = ua + ub + c; ecy = int'(ur > MASK); sr = sx(ua) + sx(ub) + c; end
      3:  begin tag = "R3"; ur = ua - ub;     ecy = int'(ua < ub);     sr = sx(ua) - sx(ub); end
      4:  begin tag = "R3"; ur = ua - ub - c; ecy = int'(ua < ub + c); sr = sx(ua) - sx(ub) - c; end
      5:  begin tag = "R4"; ur = ub - ua;     ecy = int'(ub < ua);     sr = sx(ub) - sx(ua); end
      6:  begin tag = "R4"; ur = ub - ua - c; ecy = int'(ub < ua + c); sr = sx(ub) - sx(ua) - c; end
      7:  begin tag = "R5"; ur = -ua; ecy = int'(ua != 0); sr = -sx(ua); end
      8:  begin tag = "R5"; ur = -ub; ecy = int'(ub != 0); sr = -sx(ub); end
      9:  begin tag = "R6"; ur = ua + 1; ecy = int'(ua == MASK); sr = sx(ua) + 1; end
      10: begin tag = "R6"; ur = ub + 1; ecy = int'(ub == MASK); sr = sx(ub) + 1; end
      11: begin tag = "R6"; ur = ua - 1; ecy = int'(ua != 0); sr = sx(ua) - 1; end
      12: begin tag = "R6"; ur = ub - 1; ecy = int'(ub != 0); sr = sx(ub) - 1; end
      default: ur = 0;
    endcase
    if (o >= 1 && o <= 12) eov = int'(sr > SMAX || sr < SMIN);
    eres = ur & MASK;
    @(negedge clk);
    check(tag, int'(res), eres);
    check(o > 12 ? "R10" : "R7", int'(cy), ecy);
    check(o > 12 ? "R10" : "R8", int'(of), eov);
    check("R9", int'(zf), int'(eres == 0));
    check("R9", int'(nf), (eres >> (BW - 1)) & 1);
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; op = '0; fn = '0;
    @(negedge clk);
    // initial state with all inputs zero: logic code 0000, R1 and R9
    check("R1", int'(res), 0);
    check("R9", int'(zf), 1);
    // named logic codes on a fixed pattern (R1)
    apply_and_check(0, 4'b1000, 4'b1100, 4'b1010, 0);
    apply_and_check(0, 4'b1110, 4'b1100, 4'b1010, 0);
    apply_and_check(0, 4'b0110, 4'b1100, 4'b1010, 0);
    apply_and_check(0, 4'b0011, 4'b1100, 4'b1010, 0);
    // exhaustive sweep of every code, operand pair and carry-in
    for (int o = 0; o < 16; o++)
      for (int f = 0; f < 16; f++) begin
        if (o != 0 && f != 5) continue;
        for (int ua = 0; ua <= MASK; ua++)
          for (int ub = 0; ub <= MASK; ub++)
            for (int c = 0; c < 2; c++) begin
              if (o == 0 && c == 1) continue;
              apply_and_check(o, f, ua, ub, c);
            end
      end
    // corner: most negative operand through negate, decrement and borrow paths (R8)
    apply_and_check(7, 0, 1 << (BW - 1), 0, 0);
    apply_and_check(11, 0, 1 << (BW - 1), 0, 0);
    apply_and_check(4, 0, 1 << (BW - 1), 0, 1);
    apply_and_check(9, 0, SMAX, 0, 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule